// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of a parameterised width by repeated conditional addition and right shift. It uses one adder and needs no array of partial-product logic. The multiplicand and the multiplier each have their own load strobe. The caller loads both while the block is ready, then pulses a start input. The block then alternates between an add phase and a shift phase, once per multiplier bit. It returns to ready with the double-width product on its output.

A small controller keeps its state in two flip-flops and decodes it into three strobes: idle, add and shift. An iteration counter is preset to one less than the width. The counter is tested for zero in the same cycle that it is decremented, so the loop body runs exactly as many times as the operand has bits. The add result is held in an accumulator with a carry bit. The carry is shifted into the accumulator, and the accumulator's low bit is shifted into the multiplier register. When the run ends, the upper half of the product is in the accumulator and the lower half is in the multiplier register.

Top module: `shift_add_mult`

## Requirements
- R1: After reset, `ready_o` is 1 and `product_o` is 0.
- R2: After a run, `product_o` equals the unsigned product of the loaded multiplicand and multiplier. The upper WIDTH bits come from the accumulator and the lower WIDTH bits from the multiplier register.
- R3: A start pulse sampled while ready causes `ready_o` to be 0 for exactly 2*WIDTH clock cycles: one add cycle and one shift cycle per multiplier bit.
- R4: `load_b_i` and `load_q_i` are ignored while `ready_o` is 0. They have no effect on the running result.
- R5: `start_i` is ignored while `ready_o` is 0. It neither restarts the run nor lengthens it.
- R6: While ready, with no start and no load, `product_o` holds its value.
- R7: A start without a new multiplier load uses the current multiplier register, which holds the low half of the previous product. The accumulator and the carry are cleared on every start.
- R8: The carry out of the add is kept, so the all-ones by all-ones product is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a multiplication (sampled only while ready) |
| load_b_i | input | 1 | Write `b_i` into the multiplicand register (ready only) |
| load_q_i | input | 1 | Write `q_i` into the multiplier register (ready only) |
| b_i | input | WIDTH | Multiplicand value |
| q_i | input | WIDTH | Multiplier value |
| ready_o | output | 1 | High while the controller is idle |
| product_o | output | 2*WIDTH | Accumulator concatenated with multiplier register |

## Verification
At a width of 4, every pair of operands is run. These runs cover zero operands, single set bits and alternating bit patterns; operands that give carry-out and those that never add; and the all-ones case. Each run therefore separates a wrong add condition, a lost carry or a misaligned shift. Every other run also drives loads and start during the busy window, which detects a controller or register that does not ignore them. Chained starts without a reload detect an accumulator that is not cleared or a multiplier register that is reloaded by mistake.

// File: rtl/shift_add_mult_pkg.sv
package shift_add_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_SHR  = 2'd2
  } mult_state_e;
endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import shift_add_mult_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnt_zero_i,
  output logic st_idle_o,
  output logic st_add_o,
  output logic st_shr_o
);
  mult_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_ADD;
      ST_ADD:  state_d = ST_SHR;
      ST_SHR:  state_d = cnt_zero_i ? ST_IDLE : ST_ADD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  // decoder
  assign st_idle_o = (state_q == ST_IDLE);
  assign st_add_o  = (state_q == ST_ADD);
  assign st_shr_o  = (state_q == ST_SHR);

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({st_idle_o, st_add_o, st_shr_o}));
  a_r3_add_then_shr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_add_o |=> st_shr_o);
  a_r5_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_shr_o && !cnt_zero_i) |=> st_add_o);
endmodule

// File: rtl/mult_counter.sv
module mult_counter #(
  parameter int WIDTH = 8,
  localparam int CW = (WIDTH < 2) ? 1 : $clog2(WIDTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= CW'(WIDTH - 1);
    else if (dec_i)  cnt_q <= cnt_q - CW'(1);

  assign zero_o = (cnt_q == '0);

  a_r3_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == CW'(WIDTH - 1)));
  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o || $past(load_i) == 1'b0);
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_idle_i,
  input  logic             st_add_i,
  input  logic             st_shr_i,
  input  logic             start_i,
  input  logic             load_b_i,
  input  logic             load_q_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] q_i,
  output logic             q_lsb_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic [WIDTH-1:0] a_q, q_q, b_q;
  logic             c_q;
  logic [WIDTH:0]   sum;

  assign sum = {1'b0, a_q} + {1'b0, b_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      q_q <= '0;
      b_q <= '0;
      c_q <= 1'b0;
    end else if (st_idle_i) begin
      if (load_b_i) b_q <= b_i;
      if (load_q_i) q_q <= q_i;
      if (start_i) begin
        a_q <= '0;
        c_q <= 1'b0;
      end
    end else if (st_add_i) begin
      if (q_q[0]) {c_q, a_q} <= sum;
    end else if (st_shr_i) begin
      a_q <= {c_q, a_q[WIDTH-1:1]};
      q_q <= {a_q[0], q_q[WIDTH-1:1]};
      c_q <= 1'b0;
    end
  end

  assign q_lsb_o   = q_q[0];
  assign product_o = {a_q, q_q};

  a_r4_b_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_idle_i |=> $stable(b_q));
  a_r8_carry_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_shr_i |=> !c_q);
  a_r7_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_idle_i && start_i) |=> (a_q == '0) && !c_q);
  a_r2_no_add_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_add_i && !q_q[0]) |=> $stable(a_q) && $stable(c_q));
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               load_b_i,
  input  logic               load_q_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic [WIDTH-1:0]   q_i,
  output logic               ready_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic st_idle, st_add, st_shr, cnt_zero, q_lsb;

  initial assert (WIDTH >= 2);

  mult_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cnt_zero_i (cnt_zero),
    .st_idle_o  (st_idle),
    .st_add_o   (st_add),
    .st_shr_o   (st_shr)
  );

  mult_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st_idle & start_i),
    .dec_i  (st_shr),
    .zero_o (cnt_zero)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_idle_i (st_idle),
    .st_add_i  (st_add),
    .st_shr_i  (st_shr),
    .start_i   (start_i),
    .load_b_i  (load_b_i),
    .load_q_i  (load_q_i),
    .b_i       (b_i),
    .q_i       (q_i),
    .q_lsb_o   (q_lsb),
    .product_o (product_o)
  );

  assign ready_o = st_idle;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i && !load_b_i && !load_q_i) |=> $stable(product_o));
  a_r3_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);
endmodule

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ld_b = 1'b0, ld_q = 1'b0;
  logic [W-1:0] b_in = '0, q_in = '0;
  logic ready;
  logic [2*W-1:0] prod;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_add_mult #(.WIDTH(W)) u_shift_add_mult (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .load_b_i(ld_b),
    .load_q_i(ld_q), .b_i(b_in), .q_i(q_in), .ready_o(ready), .product_o(prod)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // load (optional), start, wait; returns busy cycle count
  task automatic run(input bit do_load, input int b, input int q,
                     input bit tamper, output int busy);
    @(negedge clk);
    if (do_load) begin
      ld_b = 1'b1; ld_q = 1'b1; b_in = W'(b); q_in = W'(q);
      @(negedge clk);
      ld_b = 1'b0; ld_q = 1'b0;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy = 0;
    while (!ready && busy < 100) begin
      busy++;
      if (tamper) begin
        ld_b = 1'b1; ld_q = 1'b1; start = 1'b1;
        b_in = W'(b ^ 5); q_in = W'(q ^ 9);
      end
      @(negedge clk);
      ld_b = 1'b0; ld_q = 1'b0; start = 1'b0;
    end
  endtask

  initial begin
    int busy;
    int prev_lo, bv;
    repeat (3) @(negedge clk);
    check("R1 ready", int'(ready), 1);
    check("R1 product", int'(prod), 0);
    rst_n = 1'b1;

    for (int b = 0; b < (1 << W); b++) begin
      for (int q = 0; q < (1 << W); q++) begin
        bit tmp = ((b + q) % 2) == 1;
        run(1'b1, b, q, tmp, busy);
        if (b == (1 << W) - 1 && q == (1 << W) - 1)
          check("R8 all ones", int'(prod), b * q);
        else if (tmp)
          check("R4 R5 ignored while busy", int'(prod), b * q);
        else
          check("R2 product", int'(prod), b * q);
        check(tmp ? "R5 busy length with start held" : "R3 busy length",
              busy, 2 * W);
      end
    end

    // R6: idle hold
    run(1'b1, 11, 13, 1'b0, busy);
    repeat (4) @(negedge clk);
    check("R6 product held", int'(prod), 143);
    check("R6 still ready", int'(ready), 1);

    // R7: chained starts without reload
    bv = 7;
    run(1'b1, bv, 3, 1'b0, busy);
    for (int k = 0; k < 4; k++) begin
      prev_lo = int'(prod[W-1:0]);
      run(1'b0, 0, 0, 1'b0, busy);
      check("R7 chained start", int'(prod), bv * prev_lo);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule